// File: doc/BRIEF.md
# Age-Ordered Wakeup and Select Queue

This block is the scheduling window of a single-thread out-of-order core. Each cycle the rename stage may offer one instruction. The instruction carries an 8-bit sequence number, a 2-bit operation class, two physical source tags, a destination tag and a flag that marks it as non-speculative. The queue takes it into a free slot unless every slot is occupied. A scoreboard with one bit per physical register records which values exist. Execution units broadcast a completion tag, and that broadcast wakes every waiting source that names the same tag.

Every cycle the queue picks, among the entries whose operands are ready, the oldest entry of each operation class. It then issues the oldest of those class winners, up to the issue width, with lane 0 always the oldest. An issued entry stays in its slot until commit frees it. Commit frees every entry up to and including a given sequence number. A squash removes every entry that is younger than a given sequence number. A non-speculative entry waits for a release from commit that names its own sequence number.

Top module: `iqws_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_count` is 16, `full` is 0 and no issue lane is valid.
- R2: `free_count` equals 16 minus the number of occupied slots, and `full` is 1 exactly when it is 0. An insert offered while `full` is 1 is dropped.
- R3: Among ready entries, lane 0 carries the entry with the smallest sequence number and lane 1 the next one that is eligible. An entry is ready when both sources are ready, and also released if it is non-speculative.
- R4: At most 2 entries issue per cycle, and at most 1 per operation class. When two ready entries share a class, the younger one waits for a later cycle.
- R5: Source tag 0 is always ready. Inserting an entry with a nonzero destination tag marks that register not ready in the scoreboard, so a later consumer of the tag waits.
- R6: A completion tag broadcast in cycle t makes matching sources of queued entries ready for selection in cycle t+1. An entry inserted in cycle t with a source equal to that tag is also ready in cycle t+1.
- R7: A non-speculative entry (`ins_nonspec`=1) does not issue until a release names its sequence number. It becomes eligible in the cycle after the release.
- R8: A squash with sequence number S removes every entry younger than S and keeps S and all older entries.
- R9: A commit with sequence number C frees every entry whose sequence number is C or older.
- R10: Sequence numbers are compared modulo 256 by signed difference, so 0 is younger than 254 when both are live. The live window stays under 128.
- R11: An entry issues at most once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request this cycle |
| ins_seq | input | 8 | Sequence number of the offered instruction |
| ins_cls | input | 2 | Operation class |
| ins_srcs | input | 16 | Two source tags, source 0 in bits 7:0 |
| ins_dst | input | 8 | Destination tag, 0 means none |
| ins_nonspec | input | 1 | Hold until released by sequence number |
| wake_valid | input | 1 | Completion broadcast valid |
| wake_tag | input | 8 | Completed destination tag |
| rel_valid | input | 1 | Release of a non-speculative entry |
| rel_seq | input | 8 | Sequence number being released |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | 8 | Entries younger than this are removed |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 8 | Entries up to and including this are freed |
| free_count | output | 5 | Number of unoccupied slots |
| full | output | 1 | No slot is free |
| iss_valid | output | 2 | Per-lane issue valid |
| iss_seq | output | 16 | Per-lane sequence number, lane 0 in bits 7:0 |
| iss_cls | output | 4 | Per-lane operation class |
| iss_dst | output | 16 | Per-lane destination tag |

## Verification
The hardest case to reach is the same-cycle race. A completion broadcast lands in the same cycle that a consumer of that tag is inserted. Meanwhile two entries of one class and one of another become ready together, and the sequence numbers wrap through 255 to 0. Directed phases build each of these situations: a producer first clears a tag, consumers are parked on it, and the wake is then timed against an insert. A long pseudo-random run then mixes inserts, wakes, releases, squashes and commits while the sequence numbers wrap many times. Each cycle the bench compares both issue lanes, the free count and the full flag with a reference model that ranks entries by their distance from the oldest uncommitted number.

// File: rtl/iqws_pkg.sv
// Shared sequence-number type and age comparison for the issue queue.
// Assumes the live window of sequence numbers spans less than half the space.
package iqws_pkg;
    localparam int SEQ_W = 8;
    typedef logic [SEQ_W-1:0] seq_t;

    // True when a is older than b under modulo arithmetic.
    function automatic logic seq_older(seq_t a, seq_t b);
        logic signed [SEQ_W-1:0] diff;
        diff = a - b;
        return diff < 0;
    endfunction
endpackage

// File: rtl/iqws_scoreboard.sv
// One ready bit per physical register. Wakeup sets a bit and allocation of
// a new producer clears it; the read ports bypass a same-cycle wakeup and
// treat tag 0 as always ready. Assumes tags are below NPHYS.
module iqws_scoreboard #(
    parameter int NPHYS = 192,
    parameter int NRD   = 2,
    parameter int TAG_W = $clog2(NPHYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wake_v,
    input  logic [TAG_W-1:0] wake_tag,
    input  logic             alloc_v,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [TAG_W-1:0] rd_tag [NRD],
    output logic [NRD-1:0]   rd_rdy
);
    logic [NPHYS-1:0] sb;

    // Update the ready bits; a new producer overrides a same-tag wakeup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb <= '1;
        end else begin
            if (wake_v && wake_tag != '0) sb[wake_tag] <= 1'b1;
            if (alloc_v && alloc_tag != '0) sb[alloc_tag] <= 1'b0;
        end
    end

    // Read readiness for the incoming instruction's sources with wake bypass.
    always_comb begin
        for (int r = 0; r < NRD; r++) begin
            rd_rdy[r] = (rd_tag[r] == '0) || sb[rd_tag[r]] ||
                        (wake_v && wake_tag == rd_tag[r]);
        end
    end
endmodule

// File: rtl/iqws_class_pick.sv
// Finds the oldest requesting entry belonging to one operation class.
// Assumes sequence numbers of live entries are unique.
module iqws_class_pick
    import iqws_pkg::*;
#(
    parameter int N      = 16,
    parameter int CLS_W  = 2,
    parameter int CLS_ID = 0,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  seq_t             seq   [N],
    input  logic [CLS_W-1:0] cls   [N],
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output seq_t             best_seq
);
    // Linear scan keeping the oldest matching entry.
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_seq = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && cls[i] == CLS_W'(CLS_ID) &&
                (!found || seq_older(seq[i], best_seq))) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_seq = seq[i];
            end
        end
    end
endmodule

// File: rtl/iqws_lane_select.sv
// Orders the per-class winners by age and hands the ISSUE_W oldest to the
// issue lanes, lane 0 oldest. One winner per class gives the class limit.
module iqws_lane_select
    import iqws_pkg::*;
#(
    parameter int NCLS    = 4,
    parameter int ISSUE_W = 2,
    parameter int IDX_W   = 4
) (
    input  logic [NCLS-1:0]  cand_v,
    input  logic [IDX_W-1:0] cand_idx [NCLS],
    input  seq_t             cand_seq [NCLS],
    output logic [ISSUE_W-1:0] lane_v,
    output logic [IDX_W-1:0]   lane_idx [ISSUE_W]
);
    logic [NCLS-1:0] taken;
    int              best;
    logic            have;

    // Repeated oldest-of-remaining selection, one pass per lane.
    always_comb begin
        taken = '0;
        for (int w = 0; w < ISSUE_W; w++) begin
            have = 1'b0;
            best = 0;
            for (int c = 0; c < NCLS; c++) begin
                if (cand_v[c] && !taken[c] &&
                    (!have || seq_older(cand_seq[c], cand_seq[best]))) begin
                    have = 1'b1;
                    best = c;
                end
            end
            lane_v[w]   = have;
            lane_idx[w] = cand_idx[best];
            if (have) taken[best] = 1'b1;
        end
    end
endmodule

// File: rtl/iqws_issue_queue.sv
// Single-thread wakeup/select queue. Holds renamed instructions, tracks
// operand readiness, issues oldest-first up to ISSUE_W per cycle with one
// per class, holds non-speculative entries until released, and frees
// entries on commit or squash. Assumes one insert per cycle and a live
// sequence window under half the number space.
module iqws_issue_queue
    import iqws_pkg::*;
#(
    parameter int N       = 16,
    parameter int NSRC    = 2,
    parameter int NCLS    = 4,
    parameter int ISSUE_W = 2,
    parameter int NPHYS   = 192,
    parameter int TAG_W   = $clog2(NPHYS),
    parameter int CLS_W   = $clog2(NCLS),
    parameter int IDX_W   = $clog2(N),
    parameter int CNT_W   = $clog2(N + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ins_valid,
    input  logic [SEQ_W-1:0]          ins_seq,
    input  logic [CLS_W-1:0]          ins_cls,
    input  logic [NSRC*TAG_W-1:0]     ins_srcs,
    input  logic [TAG_W-1:0]          ins_dst,
    input  logic                      ins_nonspec,
    input  logic                      wake_valid,
    input  logic [TAG_W-1:0]          wake_tag,
    input  logic                      rel_valid,
    input  logic [SEQ_W-1:0]          rel_seq,
    input  logic                      squash_valid,
    input  logic [SEQ_W-1:0]          squash_seq,
    input  logic                      commit_valid,
    input  logic [SEQ_W-1:0]          commit_seq,
    output logic [CNT_W-1:0]          free_count,
    output logic                      full,
    output logic [ISSUE_W-1:0]        iss_valid,
    output logic [ISSUE_W*SEQ_W-1:0]  iss_seq,
    output logic [ISSUE_W*CLS_W-1:0]  iss_cls,
    output logic [ISSUE_W*TAG_W-1:0]  iss_dst
);
    logic [N-1:0]     e_v, e_iss, e_ns, e_rel, req, grant, e_allrdy;
    seq_t             e_seq [N];
    logic [CLS_W-1:0] e_cls [N];
    logic [TAG_W-1:0] e_dst [N];
    logic [TAG_W-1:0] e_src [N][NSRC];
    logic [NSRC-1:0]  e_rdy [N];

    logic [TAG_W-1:0] in_src [NSRC];
    logic [NSRC-1:0]  in_rdy;
    logic [IDX_W-1:0] alloc_idx;
    logic             alloc_ok, ins_fire;
    logic [CNT_W-1:0] used;

    logic [NCLS-1:0]  cand_v;
    logic [IDX_W-1:0] cand_idx [NCLS];
    seq_t             cand_seq [NCLS];
    logic [ISSUE_W-1:0] lane_v;
    logic [IDX_W-1:0]   lane_idx [ISSUE_W];

    // Split the packed source field into tags.
    always_comb begin
        for (int s = 0; s < NSRC; s++) in_src[s] = ins_srcs[s*TAG_W +: TAG_W];
    end

    // Occupancy count and lowest free slot.
    always_comb begin
        used      = '0;
        alloc_ok  = 1'b0;
        alloc_idx = '0;
        for (int i = 0; i < N; i++) begin
            used = used + CNT_W'(e_v[i]);
            if (!e_v[i] && !alloc_ok) begin
                alloc_ok  = 1'b1;
                alloc_idx = IDX_W'(i);
            end
        end
    end

    assign free_count = CNT_W'(N) - used;
    assign full       = !alloc_ok;
    assign ins_fire   = ins_valid && alloc_ok;

    iqws_scoreboard #(.NPHYS(NPHYS), .NRD(NSRC), .TAG_W(TAG_W)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .wake_v(wake_valid), .wake_tag(wake_tag),
        .alloc_v(ins_fire), .alloc_tag(ins_dst),
        .rd_tag(in_src), .rd_rdy(in_rdy)
    );

    // Entry eligibility for selection.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            e_allrdy[i] = &e_rdy[i];
            req[i] = e_v[i] && !e_iss[i] && e_allrdy[i] && (!e_ns[i] || e_rel[i]);
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        iqws_class_pick #(.N(N), .CLS_W(CLS_W), .CLS_ID(c), .IDX_W(IDX_W)) u_pick (
            .req(req), .seq(e_seq), .cls(e_cls),
            .found(cand_v[c]), .idx(cand_idx[c]), .best_seq(cand_seq[c])
        );
    end

    iqws_lane_select #(.NCLS(NCLS), .ISSUE_W(ISSUE_W), .IDX_W(IDX_W)) u_lanes (
        .cand_v(cand_v), .cand_idx(cand_idx), .cand_seq(cand_seq),
        .lane_v(lane_v), .lane_idx(lane_idx)
    );

    // Drive issue lanes and the per-entry grant vector.
    always_comb begin
        grant = '0;
        for (int w = 0; w < ISSUE_W; w++) begin
            iss_valid[w]                 = lane_v[w];
            iss_seq[w*SEQ_W +: SEQ_W]    = e_seq[lane_idx[w]];
            iss_cls[w*CLS_W +: CLS_W]    = e_cls[lane_idx[w]];
            iss_dst[w*TAG_W +: TAG_W]    = e_dst[lane_idx[w]];
            if (lane_v[w]) grant[lane_idx[w]] = 1'b1;
        end
    end

    // Per-entry state: allocate, wake, release, issue, commit and squash.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                e_v[i] <= 1'b0;
            end else if (e_v[i]) begin
                if (grant[i]) e_iss[i] <= 1'b1;
                for (int s = 0; s < NSRC; s++) begin
                    if (wake_valid && wake_tag == e_src[i][s]) e_rdy[i][s] <= 1'b1;
                end
                if (rel_valid && rel_seq == e_seq[i]) e_rel[i] <= 1'b1;
                if (commit_valid && !seq_older(commit_seq, e_seq[i])) e_v[i] <= 1'b0;
                if (squash_valid && seq_older(squash_seq, e_seq[i])) e_v[i] <= 1'b0;
            end else if (ins_fire && alloc_idx == IDX_W'(i)) begin
                e_v[i]   <= 1'b1;
                e_iss[i] <= 1'b0;
                e_seq[i] <= ins_seq;
                e_cls[i] <= ins_cls;
                e_dst[i] <= ins_dst;
                e_ns[i]  <= ins_nonspec;
                e_rel[i] <= 1'b0;
                e_rdy[i] <= in_rdy;
                for (int s = 0; s < NSRC; s++) e_src[i][s] <= in_src[s];
            end
        end
    end
endmodule

// File: rtl/iqws_checker.sv
// Temporal checks on the issue queue ports, bound into every instance.
module iqws_checker
    import iqws_pkg::*;
#(
    parameter int N       = 16,
    parameter int ISSUE_W = 2,
    parameter int CLS_W   = 2,
    parameter int CNT_W   = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ins_valid,
    input logic                     commit_valid,
    input logic                     squash_valid,
    input logic                     full,
    input logic [CNT_W-1:0]         free_count,
    input logic [ISSUE_W-1:0]       iss_valid,
    input logic [ISSUE_W*SEQ_W-1:0] iss_seq,
    input logic [ISSUE_W*CLS_W-1:0] iss_cls
);
    // R1: the first cycle out of reset shows an empty queue.
    p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (free_count == CNT_W'(N) && iss_valid == '0));

    // R2: full flag agrees with the free count.
    p_full_matches_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full == (free_count == '0));

    // R2: a refused insert leaves the queue full when nothing frees slots.
    p_refuse_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ins_valid && !commit_valid && !squash_valid) |=> full);

    // R11: the entry on lane 0 does not reappear next cycle without a new insert.
    p_no_reissue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[0] && !ins_valid) |=>
        !(iss_valid[0] && iss_seq[SEQ_W-1:0] == $past(iss_seq[SEQ_W-1:0])));

    for (genvar w = 1; w < ISSUE_W; w++) begin : g_lane
        // R3: later lanes carry strictly younger entries.
        p_lane_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[w] |-> (iss_valid[0] &&
            seq_older(iss_seq[SEQ_W-1:0], iss_seq[w*SEQ_W +: SEQ_W])));
        // R4: no two lanes share an operation class.
        p_class_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (iss_valid[0] && iss_valid[w]) |->
            iss_cls[CLS_W-1:0] != iss_cls[w*CLS_W +: CLS_W]);
    end
endmodule

bind iqws_issue_queue iqws_checker #(
    .N(N), .ISSUE_W(ISSUE_W), .CLS_W(CLS_W), .CNT_W(CNT_W)
) u_iqws_checker (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
    .commit_valid(commit_valid), .squash_valid(squash_valid),
    .full(full), .free_count(free_count),
    .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls)
);

// File: tb/iqws_issue_queue_bench.sv
// Bench for the issue queue: directed phases plus a long pseudo-random run,
// every cycle compared with a reference model ranking by distance from the
// oldest uncommitted sequence number.
module iqws_issue_queue_bench;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 0, ins_nonspec = 0, wake_valid = 0;
    logic        rel_valid = 0, squash_valid = 0, commit_valid = 0;
    logic [7:0]  ins_seq = 0, ins_dst = 0, wake_tag = 0, rel_seq = 0;
    logic [7:0]  squash_seq = 0, commit_seq = 0;
    logic [1:0]  ins_cls = 0;
    logic [15:0] ins_srcs = 0;
    logic [4:0]  free_count;
    logic        full;
    logic [1:0]  iss_valid;
    logic [15:0] iss_seq, iss_dst;
    logic [3:0]  iss_cls;

    always #5 clk = ~clk;

    iqws_issue_queue u_iqws_issue_queue (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_cls(ins_cls),
        .ins_srcs(ins_srcs), .ins_dst(ins_dst), .ins_nonspec(ins_nonspec),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .rel_valid(rel_valid), .rel_seq(rel_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .free_count(free_count), .full(full),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_cls(iss_cls), .iss_dst(iss_dst)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // Reference model state.
    bit       mv[N], miss[N], mns[N], mrel[N], mr0[N], mr1[N];
    bit [7:0] mseq[N], ms0[N], ms1[N], mdst[N];
    bit [1:0] mcls[N];
    bit       msb[192];
    bit [7:0] ref_seq = 8'd250, next_seq = 8'd250;

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int mcount();
        int c = 0;
        for (int i = 0; i < N; i++) c += mv[i];
        return c;
    endfunction

    function automatic bit [7:0] age(bit [7:0] s);
        return s - ref_seq;
    endfunction

    // Model selection: oldest eligible, distinct classes, two lanes.
    task automatic model_pick(output int p0, output int p1);
        int p[2];
        bit used_cls[4];
        bit picked[N];
        for (int c = 0; c < 4; c++) used_cls[c] = 0;
        for (int i = 0; i < N; i++) picked[i] = 0;
        for (int w = 0; w < 2; w++) begin
            p[w] = -1;
            for (int i = 0; i < N; i++) begin
                if (mv[i] && !miss[i] && mr0[i] && mr1[i] && (!mns[i] || mrel[i]) &&
                    !picked[i] && !used_cls[mcls[i]] &&
                    (p[w] < 0 || age(mseq[i]) < age(mseq[p[w]])))
                    p[w] = i;
            end
            if (p[w] >= 0) begin
                picked[p[w]] = 1;
                used_cls[mcls[p[w]]] = 1;
            end
        end
        p0 = p[0];
        p1 = p[1];
    endtask

    task automatic compare(string tag);
        int p0, p1;
        int pk[2];
        model_pick(p0, p1);
        pk[0] = p0;
        pk[1] = p1;
        chk(free_count == 5'(N - mcount()), {tag, " free_count"}, free_count, N - mcount());
        chk(full == (mcount() == N), {tag, " full"}, full, mcount() == N);
        for (int w = 0; w < 2; w++) begin
            chk(iss_valid[w] == (pk[w] >= 0), {tag, " lane valid"}, iss_valid[w], pk[w] >= 0);
            if (pk[w] >= 0 && iss_valid[w]) begin
                chk(iss_seq[w*8 +: 8] == mseq[pk[w]], {tag, " lane seq"},
                    iss_seq[w*8 +: 8], mseq[pk[w]]);
                chk(iss_cls[w*2 +: 2] == mcls[pk[w]], {tag, " lane class"},
                    iss_cls[w*2 +: 2], mcls[pk[w]]);
                chk(iss_dst[w*8 +: 8] == mdst[pk[w]], {tag, " lane dst"},
                    iss_dst[w*8 +: 8], mdst[pk[w]]);
            end
        end
    endtask

    // One cycle: compare, apply the driven inputs at the edge, update model.
    task automatic step(string tag);
        int p0, p1, slot;
        bit acc;
        bit [7:0] s0, s1, lim;
        compare(tag);
        model_pick(p0, p1);
        acc = ins_valid && (mcount() < N);
        slot = -1;
        for (int i = 0; i < N; i++) if (!mv[i] && slot < 0) slot = i;
        s0 = ins_srcs[7:0];
        s1 = ins_srcs[15:8];
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            if (mv[i]) begin
                if (i == p0 || i == p1) miss[i] = 1;
                if (wake_valid && wake_tag == ms0[i]) mr0[i] = 1;
                if (wake_valid && wake_tag == ms1[i]) mr1[i] = 1;
                if (rel_valid && rel_seq == mseq[i]) mrel[i] = 1;
                if (commit_valid) begin
                    lim = commit_seq + 8'd1 - ref_seq;
                    if (age(mseq[i]) < lim) mv[i] = 0;
                end
                if (squash_valid) begin
                    lim = squash_seq + 8'd1 - ref_seq;
                    if (age(mseq[i]) >= lim) mv[i] = 0;
                end
            end
        end
        if (acc) begin
            mv[slot] = 1; miss[slot] = 0; mseq[slot] = ins_seq; mcls[slot] = ins_cls;
            ms0[slot] = s0; ms1[slot] = s1; mdst[slot] = ins_dst;
            mns[slot] = ins_nonspec; mrel[slot] = 0;
            mr0[slot] = (s0 == 0) || msb[s0] || (wake_valid && wake_tag == s0);
            mr1[slot] = (s1 == 0) || msb[s1] || (wake_valid && wake_tag == s1);
            next_seq = next_seq + 8'd1;
        end
        if (wake_valid && wake_tag != 0) msb[wake_tag] = 1;
        if (acc && ins_dst != 0) msb[ins_dst] = 0;
        if (commit_valid) ref_seq = commit_seq + 8'd1;
        if (squash_valid) next_seq = squash_seq + 8'd1;
        @(negedge clk);
        ins_valid = 0; wake_valid = 0; rel_valid = 0;
        squash_valid = 0; commit_valid = 0; ins_nonspec = 0;
    endtask

    task automatic ins(bit [1:0] c, bit [7:0] s0, bit [7:0] s1, bit [7:0] d, bit ns);
        ins_valid = 1; ins_seq = next_seq; ins_cls = c;
        ins_srcs = {s1, s0}; ins_dst = d; ins_nonspec = ns;
    endtask

    task automatic wake(bit [7:0] t);
        wake_valid = 1; wake_tag = t;
    endtask

    task automatic commit_to(bit [7:0] s);
        commit_valid = 1; commit_seq = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int span, r;
        bit [7:0] t;
        for (int i = 0; i < 192; i++) msb[i] = 1;
        for (int i = 0; i < N; i++) mv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: empty after reset.
        chk(free_count == 5'd16, "R1 free_count", free_count, 16);
        chk(full == 0, "R1 full", full, 0);
        chk(iss_valid == 0, "R1 iss_valid", iss_valid, 0);

        // R5: tag 0 sources ready at once; a producer blocks its consumer.
        ins(0, 0, 0, 10, 0); step("R5");
        chk(iss_valid == 2'b01 && iss_seq[7:0] == 8'd250, "R5 ready on tag 0", iss_seq[7:0], 250);
        ins(1, 10, 0, 0, 0); step("R5");
        chk(iss_valid == 2'b00, "R5 R11 consumer waits, producer not reissued", iss_valid, 0);

        // R6: wake and same-cycle insert capture.
        wake(10); ins(2, 10, 0, 0, 0); step("R6");
        chk(iss_valid == 2'b11, "R6 both woken", iss_valid, 3);
        chk(iss_seq == {8'd252, 8'd251}, "R6 lane order", iss_seq, {8'd252, 8'd251});
        step("R11");
        chk(iss_valid == 2'b00, "R11 no reissue", iss_valid, 0);

        // R4 and R10: class limit across the 255 to 0 wrap.
        ins(3, 0, 0, 20, 0); step("R4");
        ins(3, 20, 0, 0, 0); step("R4");
        ins(3, 20, 0, 0, 0); step("R4");
        ins(0, 20, 0, 0, 0); step("R4");
        wake(20); step("R4");
        chk(iss_valid == 2'b11 && iss_seq == {8'd0, 8'd254}, "R4 R10 one per class, wrap order",
            iss_seq, {8'd0, 8'd254});
        step("R4");
        chk(iss_valid == 2'b01 && iss_seq[7:0] == 8'd255, "R4 deferred same-class", iss_seq[7:0], 255);
        step("R4");

        // R7: non-speculative hold and release.
        ins(1, 0, 0, 0, 1); step("R7");
        chk(iss_valid == 0, "R7 held", iss_valid, 0);
        step("R7");
        chk(iss_valid == 0, "R7 still held", iss_valid, 0);
        rel_valid = 1; rel_seq = 8'd1; step("R7");
        chk(iss_valid == 2'b01 && iss_seq[7:0] == 8'd1, "R7 released", iss_seq[7:0], 1);
        step("R7");

        // R9: commit frees everything up to the newest.
        commit_to(8'd1); step("R9");
        chk(free_count == 5'd16, "R9 all freed", free_count, 16);

        // R8: squash keeps the boundary entry and older ones.
        ins(0, 0, 0, 30, 0); step("R8");
        ins(0, 30, 0, 0, 0); step("R8");
        ins(1, 30, 0, 0, 0); step("R8");
        ins(2, 30, 0, 0, 0); step("R8");
        squash_valid = 1; squash_seq = 8'd3; step("R8");
        chk(free_count == 5'd14, "R8 two removed", free_count, 14);
        wake(30); step("R8");
        chk(iss_valid == 2'b01 && iss_seq[7:0] == 8'd3, "R8 only survivor issues", iss_seq[7:0], 3);
        commit_to(8'd3); step("R9");
        chk(free_count == 5'd16, "R9 freed after squash", free_count, 16);

        // R2: fill, refuse, then drain.
        ins(0, 0, 0, 40, 0); step("R2");
        commit_to(8'd4); step("R2");
        for (int k = 0; k < 16; k++) begin
            ins(2'(k), 40, 0, 0, 0); step("R2");
        end
        chk(full == 1 && free_count == 0, "R2 full", free_count, 0);
        ins(1, 0, 0, 0, 0); step("R2");
        chk(free_count == 0 && iss_valid == 0, "R2 refused insert invisible", iss_valid, 0);
        wake(40); step("R2");
        for (int k = 0; k < 10; k++) step("R2");
        commit_to(next_seq - 8'd1); step("R9");
        chk(free_count == 5'd16, "R9 drained", free_count, 16);

        // R10: long random mix with wrapping sequence numbers.
        for (int cyc = 0; cyc < 6000; cyc++) begin
            span = int'(next_seq - ref_seq);
            r = int'($urandom % 16);
            if ($urandom % 2 == 0) wake(8'($urandom % 16));
            if (r < 9) begin
                ins(2'($urandom % 4), 8'($urandom % 16), 8'($urandom % 16),
                    8'(1 + $urandom % 15), ($urandom % 10) == 0);
            end else if (r < 12 && span > 0) begin
                commit_to(ref_seq + 8'($urandom % (span < 3 ? span : 3)));
            end else if (r == 12 && span > 0) begin
                squash_valid = 1;
                squash_seq = ref_seq - 8'd1 + 8'($urandom % (span + 1));
            end else if (r >= 13) begin
                for (int i = 0; i < N; i++) begin
                    if (mv[i] && mns[i] && !mrel[i] && !rel_valid) begin
                        rel_valid = 1; rel_seq = mseq[i];
                    end
                end
            end
            t = 0;
            step("R10");
        end
        compare("R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule